// File: doc/BRIEF.md
# SCSI Bus Arbitration Controller

This block carries out bus arbitration on behalf of a single device on an 8-bit SCSI data bus. Firmware presents a one-hot device identifier and raises an arbitrate enable. The block then waits for the bus to be free for a set time. It drives BSY together with its own identifier bit and holds them for the arbitration delay. It then samples the data bus and decides whether a device of higher priority is also competing. Bit 7 carries the highest priority.

All delays come from one clock-cycle counter, so the bus-free, arbitration and settle windows are parameters counted in clock cycles. The defaults assume a 100 MHz clock: 800 ns, 2.4 us and 400 ns. Firmware polls three flags: in progress, won and lost. The block releases BSY and its identifier without firmware help in three cases: when it loses, when SCSI RST appears on the bus, and, with BSY monitoring enabled, when the BSY it is watching falls. A loss of BSY raises a sticky interrupt. While arbitration is under way, a flag tells the neighbouring parity checker to ignore the data bus.

Top module: `scsi_arb_ctrl`

## Requirements
- R1: While rst_ni is low, every output is low. After reset is released, the outputs stay low until arb_en_i is raised.
- R2: After arb_en_i rises, the block waits until bus_bsy_i and bus_sel_i have both been low on FREE_CYC consecutive clock edges. It then drives bsy_drv_o high, drives id_drv_o equal to dev_id_i, and raises arb_active_o. If BSY or SEL is seen high on any edge, the count starts again from zero.
- R3: Once bsy_drv_o has been high for ARB_CYC edges, the block samples bus_db_i. If any bit with a higher index than the set bit of dev_id_i is 1, arb_lost_o goes high, and bsy_drv_o, id_drv_o and arb_active_o go low at the same edge. Bit 7 has the highest priority.
- R4: If bus_sel_i is seen high while the block is waiting out the arbitration delay, the block loses at once: on the next edge arb_lost_o goes high and both drives are released.
- R5: If no higher-index bit is set, the block keeps driving for SETTLE_CYC further edges and then raises arb_won_o. Bits of lower index than its own are ignored.
- R6: If arb_en_i is low on an edge, the block returns to idle at that edge, with all drives and flags low.
- R7: If bus_rst_i is high on an edge while the block is waiting, arbitrating, settling or has won, it releases both drives at that edge without raising won or lost. It stays released until arb_en_i is cleared.
- R8: While bsy_mon_en_i is high, a fall of bus_bsy_i from one edge to the next sets irq_o and releases any drive at that edge. irq_o stays high until bsy_mon_en_i is low on an edge.
- R9: par_ignore_o is high only while the block waits out the arbitration delay and the settle delay. It is low when idle and after a win or a loss.
- R10: After a loss, arb_lost_o and the released drives hold until arb_en_i is cleared. Raising arb_en_i again starts a fresh bus-free wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all delays are counted in its cycles |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arb_en_i | input | 1 | Arbitrate enable from firmware; low aborts |
| dev_id_i | input | DW | One-hot device identifier |
| bsy_mon_en_i | input | 1 | Enables BSY-loss monitoring and its interrupt |
| bus_bsy_i | input | 1 | Received BSY level, active high |
| bus_sel_i | input | 1 | Received SEL level, active high |
| bus_rst_i | input | 1 | Received SCSI RST level, active high |
| bus_db_i | input | DW | Received data bus, active high |
| bsy_drv_o | output | 1 | Drive BSY onto the bus |
| id_drv_o | output | DW | Identifier bits to drive onto the data bus |
| arb_active_o | output | 1 | Arbitration has started and the bus is held |
| arb_won_o | output | 1 | Arbitration won and bus settled |
| arb_lost_o | output | 1 | Arbitration lost |
| par_ignore_o | output | 1 | Parity checker must ignore the data bus |
| irq_o | output | 1 | Sticky BSY-loss interrupt |

## Verification
A counter that is off by one shows up first at the ports. The edge at which bsy_drv_o rises, or at which won or lost appears, moves by exactly one cycle. The bench therefore samples one cycle before each expected edge and one cycle at it. A wrong priority mask gives the wrong won or lost flag ARB_CYC edges after the drive rises, and the identifier vectors that put a competitor just above or just below the block's own bit expose it. A release path that misses bus RST, SEL or BSY loss leaves bsy_drv_o high one edge after the event, and the bench checks there.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_FREE, ST_ARB, ST_SETTLE, ST_WON, ST_LOST, ST_HALT
  } arb_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/scsi_arb_timer.sv
module scsi_arb_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] lim_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == lim_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim_i)); // R2
endmodule

// File: rtl/scsi_arb_prio.sv
module scsi_arb_prio #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] own_id_i,
  input  logic [DW-1:0] bus_db_i,
  output logic          higher_o
);
  // above[i] is set when own id sits below bit i
  logic [DW-1:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 1; i < DW; i++) begin : g_mask
    assign above[i] = above[i-1] | own_id_i[i-1];
  end

  assign higher_o = |(bus_db_i & above);
endmodule

// File: rtl/scsi_bsy_mon.sv
module scsi_bsy_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic bus_bsy_i,
  output logic loss_o,
  output logic irq_o
);
  logic bsy_q;

  assign loss_o = mon_en_i && bsy_q && !bus_bsy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsy_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      bsy_q <= bus_bsy_i;
      if (!mon_en_i)   irq_o <= 1'b0;
      else if (loss_o) irq_o <= 1'b1;
    end
  end

  AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i |=> !irq_o); // R8
  AST_IRQ_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_en_i && $fell(bus_bsy_i)) |=> irq_o); // R8
endmodule

// File: rtl/scsi_arb_fsm.sv
module scsi_arb_fsm
  import scsi_arb_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned CW         = 8,
  parameter int unsigned FREE_CYC   = 80,
  parameter int unsigned ARB_CYC    = 240,
  parameter int unsigned SETTLE_CYC = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arb_en_i,
  input  logic [DW-1:0] dev_id_i,
  input  logic          bus_bsy_i,
  input  logic          bus_sel_i,
  input  logic          bus_rst_i,
  input  logic          higher_i,
  input  logic          bsy_loss_i,
  input  logic          t_done_i,
  output logic          t_run_o,
  output logic [CW-1:0] t_lim_o,
  output logic          bsy_drv_o,
  output logic [DW-1:0] id_drv_o,
  output logic          arb_active_o,
  output logic          arb_won_o,
  output logic          arb_lost_o,
  output logic          par_ignore_o
);
  arb_state_e st_q, st_d;
  logic bus_free, holding, release_evt;

  assign bus_free    = !bus_bsy_i && !bus_sel_i;
  assign release_evt = bus_rst_i || bsy_loss_i;

  always_comb begin
    st_d    = st_q;
    t_run_o = 1'b0;
    t_lim_o = CW'(FREE_CYC);
    unique case (st_q)
      ST_IDLE:      if (arb_en_i) st_d = ST_WAIT_FREE;
      ST_WAIT_FREE: begin
        t_run_o = bus_free;
        if (t_done_i) st_d = ST_ARB;
      end
      ST_ARB: begin
        t_run_o = 1'b1;
        t_lim_o = CW'(ARB_CYC);
        if (bus_sel_i)     st_d = ST_LOST;
        else if (t_done_i) st_d = higher_i ? ST_LOST : ST_SETTLE;
      end
      ST_SETTLE: begin
        t_run_o = 1'b1;
        t_lim_o = CW'(SETTLE_CYC);
        if (t_done_i) st_d = ST_WON;
      end
      default: ;
    endcase
    if (release_evt && (st_q inside {ST_WAIT_FREE, ST_ARB, ST_SETTLE, ST_WON}))
      st_d = ST_HALT;
    if (!arb_en_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign holding      = st_q inside {ST_ARB, ST_SETTLE, ST_WON};
  assign bsy_drv_o    = holding;
  assign id_drv_o     = holding ? dev_id_i : '0;
  assign arb_active_o = holding;
  assign arb_won_o    = (st_q == ST_WON);
  assign arb_lost_o   = (st_q == ST_LOST);
  assign par_ignore_o = st_q inside {ST_ARB, ST_SETTLE};

  AST_FREE_BEFORE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bsy_drv_o) |-> $past(bus_free)); // R2
  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arb_en_i |=> (!bsy_drv_o && !arb_won_o && !arb_lost_o)); // R6
  AST_RST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && bsy_drv_o) |=> (!bsy_drv_o && !arb_won_o && !arb_lost_o)); // R7
  AST_SEL_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_ignore_o && !arb_won_o && t_lim_o == CW'(ARB_CYC) && bus_sel_i
     && arb_en_i && !release_evt) |=> (arb_lost_o && !bsy_drv_o)); // R4
  AST_LOST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_o && arb_en_i) |=> arb_lost_o); // R10
endmodule

// File: rtl/scsi_arb_ctrl.sv
module scsi_arb_ctrl
  import scsi_arb_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned FREE_CYC   = 80,
  parameter int unsigned ARB_CYC    = 240,
  parameter int unsigned SETTLE_CYC = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arb_en_i,
  input  logic [DW-1:0] dev_id_i,
  input  logic          bsy_mon_en_i,
  input  logic          bus_bsy_i,
  input  logic          bus_sel_i,
  input  logic          bus_rst_i,
  input  logic [DW-1:0] bus_db_i,
  output logic          bsy_drv_o,
  output logic [DW-1:0] id_drv_o,
  output logic          arb_active_o,
  output logic          arb_won_o,
  output logic          arb_lost_o,
  output logic          par_ignore_o,
  output logic          irq_o
);
  localparam int unsigned MAX_CYC = max3(FREE_CYC, ARB_CYC, SETTLE_CYC);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic          higher, bsy_loss, t_run, t_done;
  logic [CW-1:0] t_lim;

  scsi_arb_prio #(.DW(DW)) i_prio (
    .own_id_i (dev_id_i),
    .bus_db_i (bus_db_i),
    .higher_o (higher)
  );

  scsi_bsy_mon i_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mon_en_i  (bsy_mon_en_i),
    .bus_bsy_i (bus_bsy_i),
    .loss_o    (bsy_loss),
    .irq_o     (irq_o)
  );

  scsi_arb_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (t_run),
    .lim_i  (t_lim),
    .done_o (t_done)
  );

  scsi_arb_fsm #(
    .DW(DW), .CW(CW), .FREE_CYC(FREE_CYC), .ARB_CYC(ARB_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arb_en_i     (arb_en_i),
    .dev_id_i     (dev_id_i),
    .bus_bsy_i    (bus_bsy_i),
    .bus_sel_i    (bus_sel_i),
    .bus_rst_i    (bus_rst_i),
    .higher_i     (higher),
    .bsy_loss_i   (bsy_loss),
    .t_done_i     (t_done),
    .t_run_o      (t_run),
    .t_lim_o      (t_lim),
    .bsy_drv_o    (bsy_drv_o),
    .id_drv_o     (id_drv_o),
    .arb_active_o (arb_active_o),
    .arb_won_o    (arb_won_o),
    .arb_lost_o   (arb_lost_o),
    .par_ignore_o (par_ignore_o)
  );

  AST_ID_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_id_i) |-> $onehot0(id_drv_o)); // R2
  AST_LOSS_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsy_mon_en_i && $fell(bus_bsy_i)) |=> !bsy_drv_o); // R8
endmodule

// File: tb/test_scsi_arb_ctrl.sv
module test_scsi_arb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int FREE_CYC = 80;
  localparam int ARB_CYC = 240;
  localparam int SETTLE_CYC = 40;
  // {dev_id, competing bits, expect_won}
  localparam logic [16:0] VEC [8] = '{
    {8'h08, 8'h07, 1'b1}, {8'h08, 8'h10, 1'b0}, {8'h80, 8'h7F, 1'b1},
    {8'h01, 8'h02, 1'b0}, {8'h01, 8'h00, 1'b1}, {8'h40, 8'h80, 1'b0},
    {8'h20, 8'h1F, 1'b1}, {8'h02, 8'hFC, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic arb_en = 1'b0, mon_en = 1'b0, bus_bsy = 1'b0, bus_sel = 1'b0, bus_rst = 1'b0;
  logic [DW-1:0] dev_id = '0, bus_db = '0;
  logic bsy_drv, active, won, lost, par_ign, irq;
  logic [DW-1:0] id_drv;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_arb_ctrl #(.DW(DW), .FREE_CYC(FREE_CYC), .ARB_CYC(ARB_CYC), .SETTLE_CYC(SETTLE_CYC))
  i_scsi_arb_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .arb_en_i(arb_en), .dev_id_i(dev_id),
    .bsy_mon_en_i(mon_en), .bus_bsy_i(bus_bsy), .bus_sel_i(bus_sel), .bus_rst_i(bus_rst),
    .bus_db_i(bus_db), .bsy_drv_o(bsy_drv), .id_drv_o(id_drv), .arb_active_o(active),
    .arb_won_o(won), .arb_lost_o(lost), .par_ignore_o(par_ign), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // arm and step to the first cycle of driving
  task automatic arm_to_drive(input logic [DW-1:0] id);
    dev_id = id; bus_db = '0; bus_bsy = 0; bus_sel = 0; arb_en = 1;
    cyc(FREE_CYC);
    chk("R2", "no drive before bus-free window", {31'd0, bsy_drv}, 32'd0);
    cyc(1);
    chk("R2", "bsy drive after bus free", {31'd0, bsy_drv}, 32'd1);
    chk("R2", "id drive", {24'd0, id_drv}, {24'd0, id});
    chk("R2", "in progress", {31'd0, active}, 32'd1);
  endtask

  task automatic disarm;
    arb_en = 0; bus_db = '0;
    cyc(1);
    chk("R6", "idle after clear", {26'd0, bsy_drv, active, won, lost, par_ign, |id_drv}, 32'd0);
  endtask

  task automatic run_arb(input logic [DW-1:0] id, input logic [DW-1:0] comp, input logic exp_won);
    arm_to_drive(id);
    bus_db = id | comp;
    cyc(ARB_CYC - 1);
    chk("R9", "parity ignore in delay", {31'd0, par_ign}, 32'd1);
    chk("R3", "no verdict before delay", {30'd0, won, lost}, 32'd0);
    cyc(1);
    if (exp_won) begin
      chk("R5", "still driving after compare", {31'd0, bsy_drv}, 32'd1);
      chk("R5", "not lost", {31'd0, lost}, 32'd0);
      cyc(SETTLE_CYC - 1);
      chk("R5", "won not before settle", {31'd0, won}, 32'd0);
      cyc(1);
      chk("R5", "won after settle", {31'd0, won}, 32'd1);
      chk("R9", "parity ignore low after win", {31'd0, par_ign}, 32'd0);
    end else begin
      chk("R3", "lost flag", {31'd0, lost}, 32'd1);
      chk("R3", "released on loss", {30'd0, bsy_drv, |id_drv}, 32'd0);
      chk("R9", "parity ignore low after loss", {31'd0, par_ign}, 32'd0);
      cyc(5);
      chk("R10", "lost holds", {30'd0, lost, bsy_drv}, 32'd2);
    end
    disarm();
  endtask

  initial begin
    cyc(3);
    chk("R1", "outputs in reset", {25'd0, bsy_drv, active, won, lost, par_ign, irq, |id_drv}, 32'd0);
    rst_n = 1;
    cyc(3);
    chk("R1", "outputs idle after reset", {25'd0, bsy_drv, active, won, lost, par_ign, irq, |id_drv}, 32'd0);

    for (int i = 0; i < 8; i++) run_arb(VEC[i][16:9], VEC[i][8:1], VEC[i][0]);

    // R2: a BSY glitch restarts the bus-free count
    dev_id = 8'h04; arb_en = 1;
    cyc(30);
    bus_bsy = 1; cyc(1); bus_bsy = 0;
    cyc(FREE_CYC - 1);
    chk("R2", "restart delays drive", {31'd0, bsy_drv}, 32'd0);
    cyc(1);
    chk("R2", "drive after restarted window", {31'd0, bsy_drv}, 32'd1);
    // R6: abort mid-arbitration
    cyc(20);
    arb_en = 0; cyc(1);
    chk("R6", "abort releases", {29'd0, bsy_drv, active, |id_drv}, 32'd0);

    // R4: SEL during the delay loses
    arm_to_drive(8'h80);
    cyc(10);
    bus_sel = 1; cyc(1); bus_sel = 0;
    chk("R4", "lost on SEL", {31'd0, lost}, 32'd1);
    chk("R4", "released on SEL", {31'd0, bsy_drv}, 32'd0);
    disarm();

    // R7: bus reset releases and holds off
    arm_to_drive(8'h10);
    cyc(5);
    bus_rst = 1; cyc(1); bus_rst = 0;
    chk("R7", "released on RST", {31'd0, bsy_drv}, 32'd0);
    chk("R7", "no verdict on RST", {30'd0, won, lost}, 32'd0);
    cyc(FREE_CYC + 10);
    chk("R7", "stays released", {31'd0, bsy_drv}, 32'd0);
    disarm();

    // R10: re-arm after loss restarts bus-free wait
    arm_to_drive(8'h01);
    disarm();

    // R8: BSY loss with monitoring after a win
    arm_to_drive(8'h40);
    cyc(ARB_CYC + SETTLE_CYC);
    chk("R5", "won before monitor test", {31'd0, won}, 32'd1);
    bus_bsy = 1; mon_en = 1;
    cyc(3);
    chk("R8", "no irq while BSY high", {31'd0, irq}, 32'd0);
    bus_bsy = 0; cyc(1);
    chk("R8", "irq on BSY loss", {31'd0, irq}, 32'd1);
    chk("R8", "released on BSY loss", {31'd0, bsy_drv}, 32'd0);
    cyc(4);
    chk("R8", "irq sticky", {31'd0, irq}, 32'd1);
    mon_en = 0; cyc(1);
    chk("R8", "irq clears", {31'd0, irq}, 32'd0);
    disarm();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL all watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule